// File: doc/BRIEF.md
# Pipelined Triple-DES Encryptor with Per-Stage Chaining

This block encrypts a stream of 64-bit blocks with two-key triple DES. Each of the three DES passes has its own chaining loop: the block entering a stage is XORed with that stage's own most recent result before the stage runs its DES operation. No stage waits on the final ciphertext to chain, so three blocks can be in flight at once, one in each stage.

Each stage has its own iterative DES datapath that performs one round per clock, and its own key schedule. The stages pass blocks forward with a valid/ready handshake. Once the pipe is full, a block is accepted and a ciphertext leaves every 16 cycles. A single-loop design with one DES datapath would need 48 cycles per block. Software loads the two 56-bit keys, then pulses the chain-reset input with three initial vectors, and then streams blocks in.

Top module: `tdes_inner_cbc_enc`

## Requirements
- R1: Stage 1 encrypts with K1, stage 2 decrypts with K2 and stage 3 encrypts with K1. `key_pair[111:56]` holds K1 and `key_pair[55:0]` holds K2. Each 56-bit key is split into eight 7-bit groups, most significant first, and each group forms the upper seven bits of one byte of the 64-bit DES key. The parity bits are ignored.
- R2: Each stage XORs its incoming block with its own previous result before its DES operation. After a chain reset the previous result is that stage's initial vector (`iv_s1`, `iv_s2` or `iv_s3`).
- R3: A cycle with `chain_rst` high loads the three initial vectors and discards every block in flight. No result appears for those blocks, and no block is accepted in that cycle.
- R4: With K1 equal to K2 and all initial vectors zero, the first block after a chain reset comes out as its single-DES encryption under that key.
- R5: `blk_ready` goes low in the cycle after a block is accepted and stays low until stage 1 hands that block on. A block offered while `blk_ready` is low is ignored.
- R6: A result appears on `res_out`, with `res_valid` high for exactly one cycle, 47 rising edges after the edge that accepted its block. Results appear in acceptance order.
- R7: With `blk_valid` held high, one block is accepted and one result is produced every 16 cycles.
- R8: After reset, `blk_ready` is high, `res_valid` is low and all three chaining registers hold zero.
- R9: A cycle with `key_load` high replaces both keys, and the new keys apply to blocks accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_load | input | 1 | Load `key_pair` into the key schedules |
| key_pair | input | 112 | K1 in the upper 56 bits, K2 in the lower 56 bits |
| chain_rst | input | 1 | Load the initial vectors and flush blocks in flight |
| iv_s1 | input | 64 | Initial vector for stage 1 |
| iv_s2 | input | 64 | Initial vector for stage 2 |
| iv_s3 | input | 64 | Initial vector for stage 3 |
| blk_valid | input | 1 | Input block valid |
| blk_ready | output | 1 | Stage 1 can take a block |
| blk_in | input | 64 | Plaintext block |
| res_valid | output | 1 | Ciphertext valid for one cycle |
| res_out | output | 64 | Ciphertext block |

## Verification
The embedded properties check on every cycle the handshake rules that involve no cipher value:
- `blk_ready` drops after an accept.
- A waiting result stays stable while it is stalled.
- A chain reset silences the outputs and loads the vectors into the chaining registers.
- Two results are never closer than 16 cycles apart.

Only the bench scenarios can show the following, by comparing against a three-pass model written independently:
- the cipher values themselves, including the single-DES known answer;
- that each stage chains on its own previous result;
- that blocks in flight are discarded;
- that new keys take effect;
- the exact 47-cycle latency.

// File: rtl/tdes_pkg.sv
package tdes_pkg;
  localparam int BLK_W  = 64;
  localparam int KEY_W  = 56;
  localparam int HALF_K = KEY_W / 2;
  localparam int SUBK_W = 48;
  localparam int RND_N  = 16;
  localparam int RIDX_W = $clog2(RND_N);
  localparam int CNT_W  = $clog2(RND_N + 1);

  typedef enum logic [1:0] {ST_EMPTY, ST_BUSY, ST_FULL} stg_state_e;

  // substitution boxes, entry 0 in the top nibble, index = {row, column}
  localparam logic [255:0] SBOX [8] = '{
    256'hE4D12FB83A6C59070F74E2D1A6CB953841E8D62BFC973A50FC8249175B3EA06D,
    256'hF18E6B34972DC05A3D47F28EC01A69B50E7BA4D158C6932FD8A13F42B67C05E9,
    256'hA09E63F51DC7B428D709346A285ECBF1D6498F30B12C5AE71AD069874FE3B52C,
    256'h7DE3069A1285BC4FD8B56F03472C1AE9A690CB7DF13E52843F06A1D8945BC72E,
    256'h2C417AB6853FD0E9EB2C47D150FA3986421BAD78F9C5630EB8C71E2D6F09A453,
    256'hC1AF92680D34E75BAF427C9561DE0B389EF528C3704A1DB6432C95FABE17608D,
    256'h4B2EF08D3C975A61D0B7491AE35C2F8614BDC37EAF6805926BD814A7950FE23C,
    256'hD2846FB1A93E50C71FD8A374C56B0E927B419CE206ADF35821E74A8DFC90356B};

  localparam int PERM_P [32] = '{16,7,20,21,29,12,28,17,1,15,23,26,5,18,31,10,
                                 2,8,24,14,32,27,3,9,19,13,30,6,22,11,4,25};
  localparam int PERM_PC1 [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,
                                   10,2,59,51,43,35,27,19,11,3,60,52,44,36,
                                   63,55,47,39,31,23,15,7,62,54,46,38,30,22,
                                   14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int PERM_PC2 [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,
                                   23,19,12,4,26,8,16,7,27,20,13,2,
                                   41,52,31,37,47,55,30,40,51,45,33,48,
                                   44,49,39,56,34,53,46,42,50,36,29,32};
  // total left rotation of each key half in force during round n
  localparam int ROT_CUM [16] = '{1,2,4,6,8,10,12,14,15,17,19,21,23,25,27,28};

  function automatic int ip_src(input int i);
    int r;
    int c;
    r = i / 8;
    c = i % 8;
    return ((r < 4) ? (58 + 2 * r) : (57 + 2 * (r - 4))) - 8 * c;
  endfunction

  function automatic logic [63:0] init_perm(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[63-i] = x[64-ip_src(i)];
    return y;
  endfunction

  function automatic logic [63:0] final_perm(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[64-ip_src(i)] = x[63-i];
    return y;
  endfunction

  function automatic logic [31:0] feistel(input logic [31:0] r, input logic [47:0] k);
    logic [47:0] e;
    logic [31:0] s;
    logic [31:0] p;
    logic [5:0]  six;
    int          src;
    int          idx;
    for (int i = 0; i < 48; i++) begin
      src = ((4 * (i / 6) + (i % 6) + 31) % 32) + 1;
      e[47-i] = r[32-src];
    end
    e = e ^ k;
    for (int b = 0; b < 8; b++) begin
      six = e[47-6*b -: 6];
      idx = {26'd0, six[5], six[0], six[4:1]};
      s[31-4*b -: 4] = SBOX[b][255-4*idx -: 4];
    end
    for (int i = 0; i < 32; i++) p[31-i] = s[32-PERM_P[i]];
    return p;
  endfunction

  function automatic logic [55:0] key_prep(input logic [55:0] k);
    logic [63:0] w;
    logic [55:0] cd;
    for (int b = 0; b < 8; b++) w[63-8*b -: 8] = {k[55-7*b -: 7], 1'b0};
    for (int i = 0; i < 56; i++) cd[55-i] = w[64-PERM_PC1[i]];
    return cd;
  endfunction

  function automatic logic [47:0] subkey(input logic [55:0] cd, input logic [3:0] rnd);
    logic [27:0] c;
    logic [27:0] d;
    logic [55:0] rot;
    logic [47:0] k;
    int          n;
    n = ROT_CUM[rnd];
    c = (cd[55:28] << n) | (cd[55:28] >> (HALF_K - n));
    d = (cd[27:0]  << n) | (cd[27:0]  >> (HALF_K - n));
    rot = {c, d};
    for (int i = 0; i < 48; i++) k[47-i] = rot[56-PERM_PC2[i]];
    return k;
  endfunction
endpackage

// File: rtl/tdes_key_slot.sv
module tdes_key_slot
  import tdes_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                key_we,
  input  logic [KEY_W-1:0]    key_in,
  input  logic [RIDX_W-1:0]   rnd,
  output logic [SUBK_W-1:0]   subk
);
  logic [KEY_W-1:0] cd_q;
  logic [KEY_W-1:0] cd_d;

  always_comb begin
    cd_d = cd_q;
    if (key_we) cd_d = key_prep(key_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cd_q <= '0;
    else if (key_we) cd_q <= cd_d;
  end

  assign subk = subkey(cd_q, rnd);
endmodule

// File: rtl/tdes_cbc_stage.sv
module tdes_cbc_stage
  import tdes_pkg::*;
#(
  parameter bit DECRYPT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_in,
  input  logic             chain_rst,
  input  logic [BLK_W-1:0] iv,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_data
);
  stg_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BLK_W-1:0] lr_q, lr_d, chain_q, chain_d;
  logic             accept, handoff, last, lr_en, chain_en;
  logic [RIDX_W-1:0] ridx, kidx;
  logic [SUBK_W-1:0] subk;
  logic [BLK_W-1:0]  rsrc, rout;

  assign handoff  = (st_q == ST_FULL) && out_ready && !chain_rst;
  assign in_ready = !chain_rst && ((st_q == ST_EMPTY) || handoff);
  assign accept   = in_valid && in_ready;
  assign last     = (st_q == ST_BUSY) && (cnt_q == CNT_W'(RND_N - 1));

  assign ridx = accept ? '0 : cnt_q[RIDX_W-1:0];
  assign kidx = DECRYPT ? (RIDX_W'(RND_N - 1) - ridx) : ridx;
  assign rsrc = accept ? init_perm(in_data ^ chain_q) : lr_q;
  assign rout = {rsrc[31:0], rsrc[63:32] ^ feistel(rsrc[31:0], subk)};

  tdes_key_slot u_keys (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_in(key_in),
    .rnd(kidx), .subk(subk)
  );

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    lr_d    = rout;
    chain_d = final_perm({rout[31:0], rout[63:32]});
    lr_en   = 1'b0;
    chain_en = 1'b0;
    if (chain_rst) begin
      st_d     = ST_EMPTY;
      cnt_d    = '0;
      chain_d  = iv;
      chain_en = 1'b1;
    end else begin
      if (handoff) st_d = ST_EMPTY;
      if (accept) begin
        st_d  = ST_BUSY;
        cnt_d = CNT_W'(1);
        lr_en = 1'b1;
      end else if (st_q == ST_BUSY) begin
        cnt_d = cnt_q + CNT_W'(1);
        lr_en = 1'b1;
        if (last) begin
          st_d     = ST_FULL;
          chain_en = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_EMPTY;
      cnt_q   <= '0;
      lr_q    <= '0;
      chain_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (lr_en)    lr_q    <= lr_d;
      if (chain_en) chain_q <= chain_d;
    end
  end

  assign out_valid = (st_q == ST_FULL) && !chain_rst;
  assign out_data  = chain_q;

  p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !chain_rst) |=> (chain_rst || (out_valid && $stable(out_data))));
  p_flush_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chain_rst |=> !out_valid);
  p_iv_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chain_rst |=> (out_data == $past(iv)));
endmodule

// File: rtl/tdes_inner_cbc_enc.sv
module tdes_inner_cbc_enc
  import tdes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_load,
  input  logic [2*KEY_W-1:0] key_pair,
  input  logic              chain_rst,
  input  logic [BLK_W-1:0]  iv_s1,
  input  logic [BLK_W-1:0]  iv_s2,
  input  logic [BLK_W-1:0]  iv_s3,
  input  logic              blk_valid,
  output logic              blk_ready,
  input  logic [BLK_W-1:0]  blk_in,
  output logic              res_valid,
  output logic [BLK_W-1:0]  res_out
);
  localparam int NSTG = 3;
  localparam int GAP_W = $clog2(RND_N + 1);

  logic [1:0]       sync_q;
  logic             rst_i_n;
  logic             lnk_v [NSTG+1];
  logic             lnk_r [NSTG+1];
  logic [BLK_W-1:0] lnk_d [NSTG+1];
  logic [BLK_W-1:0] ivs   [NSTG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i_n = sync_q[1];

  assign ivs[0] = iv_s1;
  assign ivs[1] = iv_s2;
  assign ivs[2] = iv_s3;

  assign lnk_v[0]    = blk_valid;
  assign lnk_d[0]    = blk_in;
  assign blk_ready   = lnk_r[0];
  assign lnk_r[NSTG] = 1'b1;
  assign res_valid   = lnk_v[NSTG];
  assign res_out     = lnk_d[NSTG];

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    tdes_cbc_stage #(.DECRYPT(g == 1)) u_stg (
      .clk(clk), .rst_n(rst_i_n), .key_we(key_load),
      .key_in((g == 1) ? key_pair[KEY_W-1:0] : key_pair[2*KEY_W-1:KEY_W]),
      .chain_rst(chain_rst), .iv(ivs[g]),
      .in_valid(lnk_v[g]), .in_ready(lnk_r[g]), .in_data(lnk_d[g]),
      .out_valid(lnk_v[g+1]), .out_ready(lnk_r[g+1]), .out_data(lnk_d[g+1])
    );
  end

  // spacing between results, counted since the previous result
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (res_valid) begin
      gap_q  <= GAP_W'(1);
      seen_q <= 1'b1;
    end else if (gap_q != GAP_W'(RND_N)) begin
      gap_q  <= gap_q + GAP_W'(1);
    end
  end

  p_rate_limit_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    res_valid |-> (!seen_q || gap_q == GAP_W'(RND_N)));
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    res_valid |=> !res_valid);
endmodule

// File: tb/tdes_inner_cbc_enc_test.sv
module tdes_inner_cbc_enc_test;
  import tdes_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          key_load = 1'b0;
  logic [111:0]  key_pair = '0;
  logic          chain_rst = 1'b0;
  logic [63:0]   iv_s1 = '0, iv_s2 = '0, iv_s3 = '0;
  logic          blk_valid = 1'b0;
  logic          blk_ready;
  logic [63:0]   blk_in = '0;
  logic          res_valid;
  logic [63:0]   res_out;

  tdes_inner_cbc_enc uut (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_pair(key_pair),
    .chain_rst(chain_rst), .iv_s1(iv_s1), .iv_s2(iv_s2), .iv_s3(iv_s3),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_in(blk_in),
    .res_valid(res_valid), .res_out(res_out)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, prev_out = 0, out_cnt = 0;
  bit stream_mode = 0, have_prev = 0, done = 0;
  logic [63:0] last_out = '0;
  logic [55:0] mk1 = '0, mk2 = '0;
  logic [63:0] mc1 = '0, mc2 = '0, mc3 = '0;
  logic [63:0] exp_d [$];
  int          exp_e [$];

  localparam int T_IP [64] = '{58,50,42,34,26,18,10,2,60,52,44,36,28,20,12,4,
                               62,54,46,38,30,22,14,6,64,56,48,40,32,24,16,8,
                               57,49,41,33,25,17,9,1,59,51,43,35,27,19,11,3,
                               61,53,45,37,29,21,13,5,63,55,47,39,31,23,15,7};
  localparam int T_E [48] = '{32,1,2,3,4,5,4,5,6,7,8,9,8,9,10,11,12,13,12,13,14,15,16,17,
                              16,17,18,19,20,21,20,21,22,23,24,25,24,25,26,27,28,29,28,29,30,31,32,1};
  localparam int T_SH [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_f(input logic [31:0] r, input logic [47:0] k);
    logic [47:0] x;
    logic [31:0] s, o;
    int row, col;
    for (int i = 1; i <= 48; i++) x[48-i] = r[32-T_E[i-1]];
    x ^= k;
    for (int b = 0; b < 8; b++) begin
      row = 2 * x[47-6*b] + x[42-6*b];
      col = 8 * x[46-6*b] + 4 * x[45-6*b] + 2 * x[44-6*b] + x[43-6*b];
      s[31-4*b -: 4] = SBOX[b][255-4*(16*row+col) -: 4];
    end
    for (int i = 1; i <= 32; i++) o[32-i] = s[32-PERM_P[i-1]];
    return o;
  endfunction

  function automatic logic [63:0] m_des(input logic [55:0] k, input logic [63:0] blk, input bit dec);
    logic [63:0] k64, t, o;
    logic [27:0] c, d;
    logic [47:0] ks [16];
    logic [55:0] cd;
    logic [31:0] l, r, tmp;
    for (int b = 0; b < 8; b++) k64[63-8*b -: 8] = {k[55-7*b -: 7], 1'b1};
    for (int i = 1; i <= 56; i++) cd[56-i] = k64[64-PERM_PC1[i-1]];
    c = cd[55:28];
    d = cd[27:0];
    for (int n = 0; n < 16; n++) begin
      for (int s = 0; s < T_SH[n]; s++) begin
        c = {c[26:0], c[27]};
        d = {d[26:0], d[27]};
      end
      for (int i = 1; i <= 48; i++) ks[n][48-i] = (PERM_PC2[i-1] <= 28) ? c[28-PERM_PC2[i-1]] : d[56-PERM_PC2[i-1]];
    end
    for (int i = 1; i <= 64; i++) t[64-i] = blk[64-T_IP[i-1]];
    l = t[63:32];
    r = t[31:0];
    for (int n = 0; n < 16; n++) begin
      tmp = r;
      r = l ^ m_f(r, ks[dec ? 15 - n : n]);
      l = tmp;
    end
    t = {r, l};
    for (int i = 1; i <= 64; i++) o[64-T_IP[i-1]] = t[64-i];
    return o;
  endfunction

  function automatic logic [55:0] squeeze(input logic [63:0] k64);
    logic [55:0] k;
    for (int b = 0; b < 8; b++) k[55-7*b -: 7] = k64[63-8*b -: 7];
    return k;
  endfunction

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  // monitor: outputs sampled at the falling edge
  always @(negedge clk) begin
    if (!done && rst_n && res_valid) begin
      out_cnt++;
      last_out = res_out;
      if (exp_d.size() == 0) begin
        check(0, "R3 unexpected result", res_out, 64'h0);
      end else begin
        check(res_out == exp_d[0], "R1 R2 result value", res_out, exp_d[0]);
        check(cyc == exp_e[0], "R6 latency edge", 64'(cyc), 64'(exp_e[0]));
        void'(exp_d.pop_front());
        void'(exp_e.pop_front());
      end
      if (stream_mode) begin
        if (have_prev) check(cyc - prev_out == 16, "R7 result spacing", 64'(cyc - prev_out), 64'd16);
        have_prev = 1;
      end
      prev_out = cyc;
    end
  end

  // callers are at posedge + 2
  task automatic load_keys(input logic [55:0] a, input logic [55:0] b);
    key_load = 1'b1;
    key_pair = {a, b};
    @(posedge clk); #2;
    key_load = 1'b0;
    mk1 = a;
    mk2 = b;
  endtask

  task automatic restart_chain(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    chain_rst = 1'b1;
    iv_s1 = a; iv_s2 = b; iv_s3 = c;
    @(posedge clk); #2;
    chain_rst = 1'b0;
    mc1 = a; mc2 = b; mc3 = c;
    exp_d.delete();
    exp_e.delete();
  endtask

  task automatic offer(input logic [63:0] d);
    logic [63:0] y1, y2, y3;
    blk_valid = 1'b1;
    blk_in = d;
    #1;
    while (!blk_ready) begin
      @(posedge clk); #3;
    end
    y1 = m_des(mk1, d ^ mc1, 1'b0); mc1 = y1;
    y2 = m_des(mk2, y1 ^ mc2, 1'b1); mc2 = y2;
    y3 = m_des(mk1, y2 ^ mc3, 1'b0); mc3 = y3;
    exp_d.push_back(y3);
    exp_e.push_back(cyc + 1 + 47);
    @(posedge clk); #1;
    check(blk_ready == 1'b0, "R5 ready low after accept", 64'(blk_ready), 64'd0);
    #1;
    blk_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ob;
    logic [55:0] kk;
    void'($urandom(32'd7331));
    #55 rst_n = 1'b1;
    idle(5);
    // R8 reset state
    check(blk_ready == 1'b1, "R8 ready after reset", 64'(blk_ready), 64'd1);
    check(res_valid == 1'b0, "R8 no result after reset", 64'(res_valid), 64'd0);

    // R8 chaining starts from zero; R9 key load takes effect; R1 distinct keys
    load_keys(squeeze(r64()), squeeze(r64()));
    offer(r64());
    offer(r64());
    idle(60);

    // R4 single-DES known answer
    kk = squeeze(64'h133457799BBCDFF1);
    load_keys(kk, kk);
    restart_chain('0, '0, '0);
    offer(64'h0123456789ABCDEF);
    idle(60);
    check(last_out == 64'h85E813540F0AB405, "R4 single DES answer", last_out, 64'h85E813540F0AB405);

    // R5 offers while not ready are ignored
    restart_chain(r64(), r64(), r64());
    offer(r64());
    blk_valid = 1'b1;
    for (int i = 0; i < 13; i++) begin
      blk_in = r64();
      #1;
      check(blk_ready == 1'b0, "R5 ready held low while busy", 64'(blk_ready), 64'd0);
      @(posedge clk); #1;
    end
    offer(r64());
    idle(70);

    // R7 back-to-back stream with new keys (R9) and vectors (R2)
    load_keys(squeeze(r64()), squeeze(r64()));
    restart_chain(r64(), r64(), r64());
    stream_mode = 1;
    have_prev = 0;
    for (int i = 0; i < 12; i++) offer(r64());
    idle(60);
    stream_mode = 0;

    // irregular arrivals
    for (int i = 0; i < 16; i++) begin
      offer(r64());
      idle($urandom_range(0, 40));
    end
    idle(60);

    // R3 flush with blocks in flight
    offer(r64());
    offer(r64());
    idle(10);
    restart_chain(r64(), r64(), r64());
    ob = out_cnt;
    idle(70);
    check(out_cnt == ob, "R3 flushed blocks produce nothing", 64'(out_cnt - ob), 64'd0);
    for (int i = 0; i < 3; i++) offer(r64());
    idle(60);

    // R9 key change between streams, equal-key corner case
    kk = squeeze(r64());
    load_keys(kk, kk);
    restart_chain(r64(), 64'hFFFFFFFFFFFFFFFF, '0);
    for (int i = 0; i < 4; i++) offer(r64());
    idle(60);
    check(exp_d.size() == 0, "R6 all results delivered", 64'(exp_d.size()), 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule